// File: doc/BRIEF.md
# Command-Sequence Write Protection Unit

This unit sits in front of a page-write engine and decides, write by write, whether a data write may reach the page buffer. It watches each write transaction (address, data byte, valid strobe) and recognises two command sequences keyed by address and data. A three-write sequence arms protection and, once protection is on, has to come before every data load. A six-write sequence removes protection. The protect state is held in a register that is cleared only by the synchronous reset.

A completed sequence opens a permit window. Any trailing data bytes (1 to 128 of them, a normal page load) are granted until the write engine reports the end of its program period with a one-cycle pulse. At that pulse the window closes and the state change requested by the sequence takes effect. This happens even when no data byte followed the sequence. The permit output is combinational and judges the write presented in the same cycle.

Top module: `wprot_gate`

## Requirements
- R1: After reset `prot_on` is 0, and every valid write is permitted.
- R2: While unprotected, every valid write gets `wr_permit`=1. This includes writes that match a command step.
- R3: The arm sequence is 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Addresses are compared on the low 15 bits. `prot_on` becomes 1 on the cycle after the next `prog_done` pulse, even if no data was written.
- R4: While protected, a data write with no completed arm sequence before it gets `wr_permit`=0. A write that matches a command step is never permitted while protected.
- R5: While protected, a completed arm sequence permits the non-command writes that follow it until `prog_done`. After that pulse a new arm sequence is needed.
- R6: The release sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Trailing writes are permitted, and `prot_on` becomes 0 on the cycle after the next `prog_done` pulse.
- R7: A write that does not match the expected step sends the recogniser back to idle. That write is judged as an ordinary write under the current state.
- R8: Address bits above bit 14 are ignored when commands are matched.
- R9: If `prog_done` comes in the same cycle as the write that completes a sequence, the pulse applies the previously requested change. The new sequence's window and requested change still take effect.
- R10: `prot_on` changes only on the cycle after a `prog_done` pulse, or on reset.
- R11: `wr_permit` is 1 only while `wr_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write transaction present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| prog_done | input | 1 | One-cycle end-of-program pulse from the write engine |
| wr_permit | output | 1 | Current write may enter the page buffer |
| prot_on | output | 1 | Protected state |

## Verification
The end-of-program pulse can arrive in the same cycle as the final write of an arm or release sequence. In that cycle one edge has to close the old window, apply the old requested change and open a new window. The bench forces this coincidence directly. Random traffic, heavy in command bytes, also produces it. In each case the bench compares `prot_on` and the permit of the next data write with a reference model that applies the old change first and then records the new one.

// File: rtl/wprot_pkg.sv
// Shared types for the write protection unit.
package wprot_pkg;
    localparam int BYTE_W = 8;

    // Recogniser position: how many command steps have matched so far.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_K1    = 3'd1,
        ST_K2    = 3'd2,
        ST_EXT   = 3'd3,
        ST_K4    = 3'd4,
        ST_K5    = 3'd5
    } seq_step_e;

    // State change waiting for the end-of-program pulse.
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_ARM     = 2'd1,
        ACT_RELEASE = 2'd2
    } pend_act_e;
endpackage

// File: rtl/wprot_seq.sv
// Command recogniser. Tracks where the write stream is inside the arm
// (3 writes) or release (6 writes) sequence.
// Assumes one write per cycle at most, and commands compared on the low CMD_AW bits.
module wprot_seq
    import wprot_pkg::*;
#(
    parameter int          CMD_AW = 15,
    parameter logic [14:0] ADR_P  = 15'h5555,
    parameter logic [14:0] ADR_Q  = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              hit,
    output logic              arm_done,
    output logic              rel_done
);
    localparam logic [BYTE_W-1:0] KEY_A  = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY_B  = 8'h55;
    localparam logic [BYTE_W-1:0] OP_ARM = 8'hA0;
    localparam logic [BYTE_W-1:0] OP_EXT = 8'h80;
    localparam logic [BYTE_W-1:0] OP_REL = 8'h20;

    seq_step_e             step_q, step_d;
    logic [CMD_AW-1:0]     exp_a;
    logic [BYTE_W-1:0]     exp_d;
    logic                  addr_ok, is_arm, is_ext, is_rel;

    // Expected address and byte for the current step.
    always_comb begin
        exp_a = ADR_P[CMD_AW-1:0];
        exp_d = KEY_A;
        case (step_q)
            ST_K1:   begin exp_a = ADR_Q[CMD_AW-1:0]; exp_d = KEY_B;  end
            ST_K2:   begin exp_a = ADR_P[CMD_AW-1:0]; exp_d = OP_ARM; end
            ST_EXT:  begin exp_a = ADR_P[CMD_AW-1:0]; exp_d = KEY_A;  end
            ST_K4:   begin exp_a = ADR_Q[CMD_AW-1:0]; exp_d = KEY_B;  end
            ST_K5:   begin exp_a = ADR_P[CMD_AW-1:0]; exp_d = OP_REL; end
            default: begin exp_a = ADR_P[CMD_AW-1:0]; exp_d = KEY_A;  end
        endcase
    end

    // Match decode for this cycle's write.
    always_comb begin
        addr_ok  = (cmd_addr == exp_a);
        is_ext   = wr_valid && addr_ok && (step_q == ST_K2) && (wr_data == OP_EXT);
        hit      = (wr_valid && addr_ok && (wr_data == exp_d)) || is_ext;
        is_arm   = hit && (step_q == ST_K2) && !is_ext;
        is_rel   = hit && (step_q == ST_K5);
        arm_done = is_arm;
        rel_done = is_rel;
    end

    // Next step: advance on a match, go back to idle on a miss or when a sequence completes.
    always_comb begin
        step_d = step_q;
        if (wr_valid) begin
            if (!hit || is_arm || is_rel) step_d = ST_IDLE;
            else if (is_ext)              step_d = ST_EXT;
            else                          step_d = seq_step_e'(step_q + 3'd1);
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_IDLE;
        else        step_q <= step_d;
    end

    // R7: a write that misses the expected step leaves the recogniser idle
    a_r7_miss_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !hit) |=> (step_q == ST_IDLE));
    a_r6_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= ST_K5);
    a_r3_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm_done && rel_done));
endmodule

// File: rtl/wprot_state.sv
// Protect state, permit window and pending change.
// Assumes prog_done is a one-cycle pulse from the write engine.
// A pulse applies the old pending change before a same-cycle completion is recorded.
module wprot_state
    import wprot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_done,
    input  logic arm_done,
    input  logic rel_done,
    output logic prot_q,
    output logic win_q
);
    pend_act_e pend_q;

    // Protect bit: updated only by the end-of-program pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot_q <= 1'b0;
        else if (prog_done && pend_q == ACT_ARM)
            prot_q <= 1'b1;
        else if (prog_done && pend_q == ACT_RELEASE)
            prot_q <= 1'b0;
    end

    // Window and pending change: a completion sets them, a pulse without completion clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= 1'b0;
            pend_q <= ACT_NONE;
        end else if (arm_done) begin
            win_q  <= 1'b1;
            pend_q <= ACT_ARM;
        end else if (rel_done) begin
            win_q  <= 1'b1;
            pend_q <= ACT_RELEASE;
        end else if (prog_done) begin
            win_q  <= 1'b0;
            pend_q <= ACT_NONE;
        end
    end

    // R10: the protect bit holds without a pulse
    a_r10_prot_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_done |=> $stable(prot_q));
    // R9: a completion always leaves the window open
    a_r9_done_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_done || rel_done) |=> win_q);
    // R5: a pulse with no completion closes the window
    a_r5_pulse_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done && !arm_done && !rel_done) |=> !win_q);
    // R1: reset leaves the unit unprotected
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !prot_q);
endmodule

// File: rtl/wprot_gate.sv
// Top of the command-sequence write protection unit. Combines the
// recogniser and state. Permit is combinational on the current write.
// Assumes the write engine sends prog_done once per program period.
module wprot_gate
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CMD_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              prog_done,
    output logic              wr_permit,
    output logic              prot_on
);
    logic hit, arm_done, rel_done, prot_q, win_q;

    wprot_seq #(.CMD_AW(CMD_AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .cmd_addr (wr_addr[CMD_AW-1:0]),
        .wr_data  (wr_data),
        .hit      (hit),
        .arm_done (arm_done),
        .rel_done (rel_done)
    );

    wprot_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_done (prog_done),
        .arm_done  (arm_done),
        .rel_done  (rel_done),
        .prot_q    (prot_q),
        .win_q     (win_q)
    );

    // Gate decision: command steps pass only when unprotected, data also passes inside a window.
    always_comb begin
        wr_permit = wr_valid && (hit ? !prot_q : (!prot_q || win_q));
        prot_on   = prot_q;
    end

    // R11: no permit without a write
    a_r11_permit_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> wr_valid);
    // R4: protected, outside a window, nothing gets through
    a_r4_locked_block: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && !win_q) |-> !wr_permit);
    // R2: unprotected passes every write
    a_r2_open_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_on && wr_valid) |-> wr_permit);
endmodule

// File: tb/sim_wprot_gate.sv
module sim_wprot_gate;
    localparam int CLK_NS = 10;
    localparam int AW     = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          prog_done = 1'b0;
    logic          wr_permit, prot_on;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    // reference model state
    int m_step = 0;
    bit m_prot = 0, m_win = 0;
    int m_pend = 0; // 0 none, 1 arm, 2 release

    always #(CLK_NS/2) clk = ~clk;

    wprot_gate #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_done(prog_done),
        .wr_permit(wr_permit), .prot_on(prot_on)
    );

    function automatic bit m_hit(int st, logic [AW-1:0] a, logic [7:0] d);
        logic [14:0] la;
        la = a[14:0];
        case (st)
            0: return la == 15'h5555 && d == 8'hAA;
            1: return la == 15'h2AAA && d == 8'h55;
            2: return la == 15'h5555 && (d == 8'hA0 || d == 8'h80);
            3: return la == 15'h5555 && d == 8'hAA;
            4: return la == 15'h2AAA && d == 8'h55;
            default: return la == 15'h5555 && d == 8'h20;
        endcase
    endfunction

    function automatic bit m_permit(bit v, logic [AW-1:0] a, logic [7:0] d);
        if (!v) return 1'b0;
        if (m_hit(m_step, a, d)) return !m_prot;
        return !m_prot || m_win;
    endfunction

    task automatic chk(bit act, bit exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check permit, update model at posedge, check protect state.
    task automatic cyc(bit v, logic [AW-1:0] a, logic [7:0] d, bit pd, string req);
        bit h, arm, rel;
        @(negedge clk);
        wr_valid = v; wr_addr = a; wr_data = d; prog_done = pd;
        #1;
        chk(wr_permit, m_permit(v, a, d), req);
        h   = v && m_hit(m_step, a, d);
        arm = h && m_step == 2 && d == 8'hA0;
        rel = h && m_step == 5;
        @(posedge clk);
        if (pd) begin
            if (m_pend == 1) m_prot = 1;
            if (m_pend == 2) m_prot = 0;
        end
        if (arm)      begin m_win = 1; m_pend = 1; end
        else if (rel) begin m_win = 1; m_pend = 2; end
        else if (pd)  begin m_win = 0; m_pend = 0; end
        if (v) begin
            if (!h || arm || rel) m_step = 0;
            else if (m_step == 2) m_step = 3;
            else m_step = m_step + 1;
        end
        #1;
        wr_valid = 0; prog_done = 0;
        chk(prot_on, m_prot, {req, " prot"});
    endtask

    task automatic arm_seq(logic [AW-1:0] hi, string req);
        cyc(1, hi | 17'h5555, 8'hAA, 0, req);
        cyc(1, hi | 17'h2AAA, 8'h55, 0, req);
        cyc(1, hi | 17'h5555, 8'hA0, 0, req);
    endtask

    task automatic rel_seq(bit pd_last, string req);
        cyc(1, 17'h5555, 8'hAA, 0, req);
        cyc(1, 17'h2AAA, 8'h55, 0, req);
        cyc(1, 17'h5555, 8'h80, 0, req);
        cyc(1, 17'h5555, 8'hAA, 0, req);
        cyc(1, 17'h2AAA, 8'h55, 0, req);
        cyc(1, 17'h5555, 8'h20, pd_last, req);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd7411);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(prot_on, 1'b0, "R1 reset");
        cyc(1, 17'h00123, 8'h3C, 0, "R1 write after reset");
        // R2: command bytes pass as data while unprotected
        cyc(1, 17'h5555, 8'hAA, 0, "R2 cmd pass");
        cyc(1, 17'h2AAA, 8'h55, 0, "R2 cmd pass");
        cyc(1, 17'h00010, 8'h11, 0, "R2 data");
        // R3: arm with no data, effective at pulse
        arm_seq('0, "R3 arm");
        cyc(0, '0, '0, 0, "R3 before pulse");
        chk(prot_on, 1'b0, "R3 still open");
        cyc(0, '0, '0, 1, "R3 pulse");
        chk(prot_on, 1'b1, "R3 armed");
        // R4: unguarded write and command steps blocked
        cyc(1, 17'h00200, 8'h42, 0, "R4 no preamble");
        cyc(1, 17'h5555, 8'hAA, 0, "R4 cmd blocked");
        // R7: broken sequence, write judged as ordinary (blocked)
        cyc(1, 17'h2AAB, 8'h55, 0, "R7 miss");
        // R5 + R8: preamble with high address bits set, then data
        arm_seq(17'h18000, "R8 high bits");
        for (int i = 0; i < 4; i++) cyc(1, 17'h00400 + i, 8'(i), 0, "R5 trailing");
        cyc(1, 17'h00404, 8'h77, 1, "R5 last byte with pulse");
        cyc(1, 17'h00405, 8'h78, 0, "R5 window closed");
        // R9: pulse coincides with release completion
        arm_seq('0, "R9 arm");
        rel_seq(1'b1, "R9 release with pulse");
        chk(prot_on, 1'b1, "R9 old arm applied");
        cyc(1, 17'h00500, 8'h99, 0, "R9 window kept");
        cyc(0, '0, '0, 1, "R6 pulse");
        chk(prot_on, 1'b0, "R6 released");
        // R6: release from protected after re-arming, with data
        arm_seq('0, "R6 arm");
        cyc(0, '0, '0, 1, "R6 arm pulse");
        rel_seq(1'b0, "R6 release");
        cyc(1, 17'h00600, 8'h5A, 0, "R6 trailing");
        cyc(0, '0, '0, 1, "R6 end");
        // R11: no write, no permit
        cyc(0, 17'h5555, 8'hAA, 0, "R11 idle");
        // random traffic biased to command values (R10 prot checked every cycle)
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a;
            logic [7:0] d;
            int r;
            r = $urandom_range(0, 9);
            case ($urandom_range(0, 3))
                0: a = 17'h5555;
                1: a = 17'h2AAA;
                2: a = {2'($urandom), 15'h5555};
                default: a = AW'($urandom);
            endcase
            case (r)
                0, 1: d = 8'hAA;
                2, 3: d = 8'h55;
                4:    d = 8'hA0;
                5:    d = 8'h80;
                6:    d = 8'h20;
                default: d = 8'($urandom);
            endcase
            cyc($urandom_range(0, 5) != 0, a, d, $urandom_range(0, 11) == 0, "R10 random");
        end
        ended = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule